// File: doc/BRIEF.md
# Power-Constrained Clock Period Selector

This block picks a clock period for each cycle of a scan or functional test. A stream of per-cycle switching energies arrives, worked out ahead of time. For each energy the block chooses the shortest of four programmed periods that meets two limits. The period must cover the critical-path delay of the circuit under test. The energy spent in the cycle, spread over that period, must also stay within the rated peak power. The result is a small period code that the tester uses to pick a waveform for that cycle. Alongside it the block keeps two running sums: the time the test takes with the chosen periods, and the time it would take with the longest period on every cycle.

The four periods come in on a packed bus, shortest in slot 0 and longest in slot 3. The power limit is tested as a product rather than a quotient, energy ≤ rated power × period, so the block has no divider. All four candidates are compared in parallel. A fixed-period mode sends every cycle to slot 3. This gives the fixed-clock baseline when the same energy stream is replayed. If no period meets both limits, the block raises a miss flag and falls back to slot 3.

Top module: `cyc_period_sel`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `out_valid`, `out_code`, `out_miss`, `total_time` and `sync_total` are all 0. `in_ready` goes to 1 on the first clock edge after reset is released.
- R2: An energy is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is 1 for exactly the one cycle that follows that edge, and is 0 after any edge with no acceptance.
- R3: When `out_miss` is 0, the period in the slot named by `out_code` is no shorter than `crit_dly` as it stood when the energy was accepted.
- R4: When `out_miss` is 0, the accepted energy is ≤ `rated_pwr` × (period of the chosen slot). The product is taken at full precision.
- R5: In variable mode (`sync_mode` = 0), `out_code` is the lowest slot index whose period meets both the R3 and the R4 limit. With periods in ascending order, this is the shortest period that qualifies.
- R6: If no slot meets both limits in variable mode, `out_miss` = 1 and `out_code` = 3, the longest slot.
- R7: In fixed mode (`sync_mode` = 1), `out_code` = 3 for every energy. `out_miss` = 1 exactly when slot 3 fails the R3 or the R4 limit.
- R8: On each acceptance, `total_time` grows by the period of the chosen slot and `sync_total` grows by the period in slot 3. Both updates are visible in the same cycle as `out_valid`.
- R9: With periods programmed in ascending order and unchanged, `total_time` never exceeds `sync_total`.
- R10: A cycle with `in_valid` low leaves `total_time` and `sync_total` unchanged and gives no `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 sends every cycle to the longest slot |
| rated_pwr | input | P_W | Rated peak power, in energy units per time unit |
| crit_dly | input | T_W | Critical-path delay, in time units |
| per_tab | input | NPER*T_W | Four periods; slot k at bits [k*T_W +: T_W], ascending |
| in_valid | input | 1 | Energy value present |
| in_energy | input | E_W | Switching energy of the test cycle |
| in_ready | output | 1 | Block accepts energies |
| out_valid | output | 1 | Code and flag valid this cycle |
| out_code | output | CODE_W | Selected slot index |
| out_miss | output | 1 | No slot met both limits |
| total_time | output | TOT_W | Sum of chosen periods |
| sync_total | output | TOT_W | Sum of longest periods |

## Verification
The hardest case to reach is the boundary where energy equals the product of power and period exactly. An energy one unit higher must push the choice up one slot. A coarse random stream rarely lands on these edges. The bench therefore sweeps energy finely across its whole range, under several rated powers and critical delays, including a zero power. With zero power, only zero energy can fit. One critical delay is longer than every period, which forces the miss path. Every point is replayed in both modes, and the running sums are compared against a model. The model derives the required period by ceiling division rather than by multiplication.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic {MODE_VARIABLE = 1'b0, MODE_FIXED = 1'b1} cps_mode_e;

  // Power limit without division: energy <= power * period.
  function automatic logic power_ok(logic [63:0] energy, logic [63:0] pwr,
                                    logic [63:0] period);
    return energy <= (pwr * period);
  endfunction

  // Structural limit: period must cover the critical path.
  function automatic logic delay_ok(logic [63:0] period, logic [63:0] crit);
    return period >= crit;
  endfunction

endpackage

// File: rtl/cps_fit_check.sv
module cps_fit_check #(
  parameter int E_W = 12,
  parameter int P_W = 4,
  parameter int T_W = 8
) (
  input  logic [E_W-1:0] energy,
  input  logic [P_W-1:0] rated,
  input  logic [T_W-1:0] crit,
  input  logic [T_W-1:0] period,
  output logic           fit,
  output logic           slow_enough,
  output logic           cool_enough
);
  import cps_pkg::*;

  always_comb begin
    slow_enough = delay_ok(64'(period), 64'(crit));
    cool_enough = power_ok(64'(energy), 64'(rated), 64'(period));
    fit         = slow_enough && cool_enough;
  end

endmodule

// File: rtl/cps_pick.sv
module cps_pick #(
  parameter int NPER   = 4,
  parameter int CODE_W = 2
) (
  input  logic [NPER-1:0]   fit_vec,
  input  logic              fixed_mode,
  output logic [CODE_W-1:0] code,
  output logic              miss
);

  always_comb begin
    code = CODE_W'(NPER-1);
    miss = 1'b1;
    if (fixed_mode) begin
      miss = !fit_vec[NPER-1];
    end else begin
      // Scan downward so the lowest fitting slot wins.
      for (int k = NPER-1; k >= 0; k--) begin
        if (fit_vec[k]) begin
          code = CODE_W'(k);
          miss = 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/cps_accum.sv
module cps_accum #(
  parameter int T_W   = 8,
  parameter int TOT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [T_W-1:0]   step,
  input  logic [T_W-1:0]   ref_step,
  output logic [TOT_W-1:0] total,
  output logic [TOT_W-1:0] ref_total
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total     <= '0;
      ref_total <= '0;
    end else if (fire) begin
      total     <= total + TOT_W'(step);
      ref_total <= ref_total + TOT_W'(ref_step);
    end
  end

endmodule

// File: rtl/cyc_period_sel.sv
module cyc_period_sel #(
  parameter int E_W    = 12,
  parameter int P_W    = 4,
  parameter int T_W    = 8,
  parameter int NPER   = 4,
  parameter int TOT_W  = 32,
  parameter int CODE_W = $clog2(NPER)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_mode,
  input  logic [P_W-1:0]       rated_pwr,
  input  logic [T_W-1:0]       crit_dly,
  input  logic [NPER*T_W-1:0]  per_tab,
  input  logic                 in_valid,
  input  logic [E_W-1:0]       in_energy,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [CODE_W-1:0]    out_code,
  output logic                 out_miss,
  output logic [TOT_W-1:0]     total_time,
  output logic [TOT_W-1:0]     sync_total
);
  import cps_pkg::*;

  localparam int LAST = NPER - 1;

  logic              ready_q;
  logic              acc_fire;
  logic [NPER-1:0]   fit_vec;
  logic [NPER-1:0]   delay_vec;
  logic [NPER-1:0]   power_vec;
  logic [CODE_W-1:0] pick_code;
  logic              pick_miss;
  logic [T_W-1:0]    pick_period;
  logic [T_W-1:0]    longest_period;
  cps_mode_e         mode;

  assign mode     = cps_mode_e'(sync_mode);
  assign in_ready = ready_q;
  assign acc_fire = in_valid && ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  for (genvar k = 0; k < NPER; k++) begin : g_slot
    cps_fit_check #(.E_W(E_W), .P_W(P_W), .T_W(T_W)) u_fit (
      .energy      (in_energy),
      .rated       (rated_pwr),
      .crit        (crit_dly),
      .period      (per_tab[k*T_W +: T_W]),
      .fit         (fit_vec[k]),
      .slow_enough (delay_vec[k]),
      .cool_enough (power_vec[k])
    );
  end

  cps_pick #(.NPER(NPER), .CODE_W(CODE_W)) u_pick (
    .fit_vec    (fit_vec),
    .fixed_mode (mode == MODE_FIXED),
    .code       (pick_code),
    .miss       (pick_miss)
  );

  assign pick_period    = per_tab[pick_code*T_W +: T_W];
  assign longest_period = per_tab[LAST*T_W +: T_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_miss  <= 1'b0;
    end else begin
      out_valid <= acc_fire;
      if (acc_fire) begin
        out_code <= pick_code;
        out_miss <= pick_miss;
      end
    end
  end

  cps_accum #(.T_W(T_W), .TOT_W(TOT_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (acc_fire),
    .step      (pick_period),
    .ref_step  (longest_period),
    .total     (total_time),
    .ref_total (sync_total)
  );

endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int E_W    = 12,
  parameter int P_W    = 4,
  parameter int T_W    = 8,
  parameter int NPER   = 4,
  parameter int TOT_W  = 32,
  parameter int CODE_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sync_mode,
  input logic [P_W-1:0]      rated_pwr,
  input logic [T_W-1:0]      crit_dly,
  input logic [NPER*T_W-1:0] per_tab,
  input logic                in_valid,
  input logic [E_W-1:0]      in_energy,
  input logic                in_ready,
  input logic                acc_fire,
  input logic                out_valid,
  input logic [CODE_W-1:0]   out_code,
  input logic                out_miss,
  input logic [TOT_W-1:0]    total_time,
  input logic [TOT_W-1:0]    sync_total
);
  localparam int LAST = NPER - 1;

  logic [E_W-1:0]      e_q;
  logic [P_W-1:0]      p_q;
  logic [T_W-1:0]      c_q;
  logic                m_q;
  logic [NPER*T_W-1:0] tab_q;
  logic [TOT_W-1:0]    tot_q;
  logic [TOT_W-1:0]    ref_q;
  logic [T_W-1:0]      chosen;
  logic [T_W-1:0]      longest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q <= '0; p_q <= '0; c_q <= '0; m_q <= 1'b0; tab_q <= '0;
      tot_q <= '0; ref_q <= '0;
    end else begin
      tot_q <= total_time;
      ref_q <= sync_total;
      if (in_valid && in_ready) begin
        e_q <= in_energy; p_q <= rated_pwr; c_q <= crit_dly;
        m_q <= sync_mode; tab_q <= per_tab;
      end
    end
  end

  assign chosen  = tab_q[out_code*T_W +: T_W];
  assign longest = tab_q[LAST*T_W +: T_W];

  // R2
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fire |=> !out_valid);
  // R3
  delay_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_miss) |-> chosen >= c_q);
  // R4
  power_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_miss) |-> 64'(e_q) <= 64'(p_q) * 64'(chosen));
  // R6
  miss_longest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> out_code == CODE_W'(LAST));
  // R7
  fixed_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && m_q) |-> out_code == CODE_W'(LAST));
  // R8
  total_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (total_time == tot_q + TOT_W'(chosen)) &&
                  (sync_total == ref_q + TOT_W'(longest)));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (total_time == tot_q) && (sync_total == ref_q));

endmodule

bind cyc_period_sel cps_checker #(
  .E_W(E_W), .P_W(P_W), .T_W(T_W), .NPER(NPER), .TOT_W(TOT_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .rated_pwr(rated_pwr),
  .crit_dly(crit_dly), .per_tab(per_tab), .in_valid(in_valid),
  .in_energy(in_energy), .in_ready(in_ready), .acc_fire(acc_fire),
  .out_valid(out_valid), .out_code(out_code), .out_miss(out_miss),
  .total_time(total_time), .sync_total(sync_total)
);

// File: tb/cyc_period_sel_bench.sv
module cyc_period_sel_bench;
  localparam int CLK_NS = 10;
  localparam int E_W = 12, P_W = 4, T_W = 8, NPER = 4, TOT_W = 32, CODE_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0;
  logic [P_W-1:0] rated_pwr = '0;
  logic [T_W-1:0] crit_dly = '0;
  logic [NPER*T_W-1:0] per_tab;
  logic in_valid = 1'b0;
  logic [E_W-1:0] in_energy = '0;
  logic in_ready, out_valid, out_miss;
  logic [CODE_W-1:0] out_code;
  logic [TOT_W-1:0] total_time, sync_total;

  int n_vec = 0, n_bad = 0;
  longint exp_tot = 0, exp_ref = 0;
  int pers [NPER] = '{20, 30, 41, 50};

  always #(CLK_NS/2) clk = ~clk;

  assign per_tab = {8'(pers[3]), 8'(pers[2]), 8'(pers[1]), 8'(pers[0])};

  cyc_period_sel #(.E_W(E_W), .P_W(P_W), .T_W(T_W), .NPER(NPER), .TOT_W(TOT_W))
    u_cyc_period_sel (.*);

  task automatic check(input bit ok, input string req, input longint act,
                       input longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Model: required period by ceiling division, then the first slot covering it.
  task automatic apply(input int e, input int p, input int c, input bit fx);
    longint need;
    int code;
    bit miss;
    if (p == 0) need = (e == 0) ? 0 : 64'd1 << 40;
    else        need = (e + p - 1) / p;
    if (c > need) need = c;
    code = NPER - 1;
    miss = 1'b1;
    if (fx) miss = pers[NPER-1] < need;
    else begin
      for (int k = NPER - 1; k >= 0; k--)
        if (pers[k] >= need) begin code = k; miss = 1'b0; end
    end
    exp_tot += pers[code];
    exp_ref += pers[NPER-1];
    @(negedge clk);
    in_valid = 1'b1; in_energy = E_W'(e); rated_pwr = P_W'(p);
    crit_dly = T_W'(c); sync_mode = fx;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R2 out_valid", longint'(out_valid), 1);
    if (fx) check(out_code == CODE_W'(code), "R7 code", longint'(out_code), code);
    else if (miss) check(out_code == CODE_W'(code), "R6 code", longint'(out_code), code);
    else check(out_code == CODE_W'(code), "R5 code (R3/R4 limits)", longint'(out_code), code);
    check(out_miss == miss, fx ? "R7 miss" : "R6 miss", longint'(out_miss), longint'(miss));
    check(total_time == TOT_W'(exp_tot), "R8 total", longint'(total_time), exp_tot);
    check(sync_total == TOT_W'(exp_ref), "R8 sync total", longint'(sync_total), exp_ref);
    check(total_time <= sync_total, "R9 bound", longint'(total_time), longint'(sync_total));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    int rl [4] = '{0, 1, 3, 15};
    int cl [4] = '{0, 25, 45, 60};
    @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b0, "R1 in_ready", longint'(in_ready), 0);
    check(out_valid == 1'b0 && out_miss == 1'b0 && out_code == '0, "R1 outputs",
          longint'({out_valid, out_miss, out_code}), 0);
    check(total_time == '0 && sync_total == '0, "R1 totals",
          longint'(total_time), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", longint'(in_ready), 1);
    for (int fx = 0; fx < 2; fx++)
      for (int ri = 0; ri < 4; ri++)
        for (int ci = 0; ci < 4; ci++)
          for (int e = 0; e < 4096; e += 13)
            apply(e, rl[ri], cl[ci], fx[0]);
    // Exact product boundaries with power 3: 60 -> slot 0, 61 -> slot 1 (R4, R5)
    apply(60, 3, 0, 1'b0);
    apply(61, 3, 0, 1'b0);
    apply(150, 3, 0, 1'b0);
    apply(151, 3, 0, 1'b0);
    // R10: idle cycles leave the totals alone
    repeat (5) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R10 no valid", longint'(out_valid), 0);
      check(total_time == TOT_W'(exp_tot), "R10 total held", longint'(total_time), exp_tot);
      check(sync_total == TOT_W'(exp_ref), "R10 sync held", longint'(sync_total), exp_ref);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule